// File: doc/BRIEF.md
# Paired-Page Translation Lookup

This block is a small fully associative translation buffer. Each entry maps two adjacent virtual pages, an even page and an odd page, that share one tag. A per-entry page mask sets the page size. The mask decides how many address bits take part in the tag compare, and it also decides which address bit picks the even or the odd half of the pair. The smallest page is 4 KiB, so the smallest pair covers 8 KiB.

A lookup is purely combinational. The caller presents a 32-bit virtual address, a write flag and the current 8-bit address-space tag. In the same cycle the block returns a physical address, a read grant, a write grant and a 3-bit result code. The code separates four outcomes: a clean translation, no entry found, an entry found whose selected half is not valid, and a write to a half that is not yet marked writable.

A write port loads one whole entry per clock edge. It is used by the fill and maintenance code that manages the buffer.

Top module: `ptlb_lookup`

## Requirements
- R1: After a synchronous active-low reset, every field of every entry is zero. A lookup with a nonzero address-space tag then returns code 1 (no-match), with both grants low and a physical address of zero.
- R2: An entry's tag compare uses virtual address bits [31:13] against the stored tag, and ignores every bit position where the entry's mask field has a one. Mask field bit j stands for address bit 13+j, and the mask must be a run of ones starting at bit 0. Address bits [12:0] never take part in the compare.
- R3: A tag-equal entry counts as found only when its global bit is set, or when its stored 8-bit address-space tag equals the current one. Otherwise the entry is skipped.
- R4: The half is chosen by the address bit just above the single-page offset: bit 12 for 4 KiB pages, and bit 12+n when the mask holds n ones. A zero in that bit selects the even half and a one selects the odd half.
- R5: When the selected half's valid bit is clear, the result is code 2 (invalid), for reads and for writes alike.
- R6: A write to a valid half whose dirty bit is clear returns code 3 (modified), not a match.
- R7: On code 0 (match), the physical address is the selected half's 20-bit frame number shifted left by 12, ORed with the virtual address bits inside one page of the entry's size. Read is granted, and write is granted exactly when the half's dirty bit is set.
- R8: For any code other than 0, the physical address, the read grant and the write grant are all zero.
- R9: When several entries are found, the entry with the lowest index decides the outcome, even if that outcome is invalid or modified.
- R10: The write port replaces the addressed entry at the clock edge. A lookup in the cycle of the write still sees the old contents, and the new contents are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_va | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 = the access is a store |
| lk_asid | input | 8 | Current address-space tag |
| lk_pa | output | 32 | Translated physical address |
| lk_rd_ok | output | 1 | Read permitted |
| lk_wr_ok | output | 1 | Write permitted |
| lk_result | output | 3 | 0 match, 1 no-match, 2 invalid, 3 modified |
| wr_en | input | 1 | Load an entry this cycle |
| wr_idx | input | 4 | Entry to load |
| wr_tag | input | 19 | Virtual pair tag (address bits 31:13) |
| wr_mask | input | 19 | Page mask field |
| wr_asid | input | 8 | Entry address-space tag |
| wr_global | input | 1 | Entry ignores the address-space tag |
| wr_pfn_even | input | 20 | Even-half frame number |
| wr_v_even | input | 1 | Even-half valid |
| wr_d_even | input | 1 | Even-half writable (dirty) |
| wr_pfn_odd | input | 20 | Odd-half frame number |
| wr_v_odd | input | 1 | Odd-half valid |
| wr_d_odd | input | 1 | Odd-half writable (dirty) |

## Verification
The assertions check the output relations on every cycle. Any result other than match carries a zero address and no grants. A match always grants read and passes the page offset through unchanged. A write grant only appears on a match, a store that matches is always granted, and the code never leaves its four values. Only the bench scenarios can show whether the right entry and half were chosen. They cover the large-page mask, the address-space and global rules, the lowest-index choice between overlapping entries, and the edge at which a loaded entry becomes visible.

// File: rtl/ptlb_pkg.sv
// Shared definitions for the paired-page translation lookup.
// Assumes: result codes are consumed as a 3-bit field by the caller.
package ptlb_pkg;
    typedef enum logic [2:0] {
        RES_HIT      = 3'd0,
        RES_MISS     = 3'd1,
        RES_INVALID  = 3'd2,
        RES_MODIFIED = 3'd3
    } ptlb_res_e;
endpackage

// File: rtl/ptlb_store.sv
// Entry storage: NUM_ENT entries loaded one per cycle through a write port.
// Assumes: wr_idx < NUM_ENT; readers see registered contents only.
module ptlb_store #(
    parameter int NUM_ENT = 16,
    parameter int TAG_W   = 19,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [TAG_W-1:0]  wr_mask,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic [PFN_W-1:0]  wr_pfn_even,
    input  logic              wr_v_even,
    input  logic              wr_d_even,
    input  logic [PFN_W-1:0]  wr_pfn_odd,
    input  logic              wr_v_odd,
    input  logic              wr_d_odd,
    output logic [TAG_W-1:0]  tag_q   [NUM_ENT],
    output logic [TAG_W-1:0]  mask_q  [NUM_ENT],
    output logic [ASID_W-1:0] asid_q  [NUM_ENT],
    output logic              glob_q  [NUM_ENT],
    output logic [PFN_W-1:0]  pfn0_q  [NUM_ENT],
    output logic              v0_q    [NUM_ENT],
    output logic              d0_q    [NUM_ENT],
    output logic [PFN_W-1:0]  pfn1_q  [NUM_ENT],
    output logic              v1_q    [NUM_ENT],
    output logic              d1_q    [NUM_ENT]
);
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        // Clear the entry on reset, replace it whole when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[g]  <= '0;
                mask_q[g] <= '0;
                asid_q[g] <= '0;
                glob_q[g] <= 1'b0;
                pfn0_q[g] <= '0;
                v0_q[g]   <= 1'b0;
                d0_q[g]   <= 1'b0;
                pfn1_q[g] <= '0;
                v1_q[g]   <= 1'b0;
                d1_q[g]   <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                tag_q[g]  <= wr_tag;
                mask_q[g] <= wr_mask;
                asid_q[g] <= wr_asid;
                glob_q[g] <= wr_global;
                pfn0_q[g] <= wr_pfn_even;
                v0_q[g]   <= wr_v_even;
                d0_q[g]   <= wr_d_even;
                pfn1_q[g] <= wr_pfn_odd;
                v1_q[g]   <= wr_v_odd;
                d1_q[g]   <= wr_d_odd;
            end
        end
    end
endmodule

// File: rtl/ptlb_match.sv
// Per-entry compare: masked tag equality, address-space check, half select.
// Assumes: mask fields are a contiguous run of ones from bit 0.
module ptlb_match #(
    parameter int NUM_ENT = 16,
    parameter int ADDR_W  = 32,
    parameter int MIN_PG  = 12,
    parameter int ASID_W  = 8,
    localparam int OFF_W  = MIN_PG + 1,
    localparam int TAG_W  = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] va,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [TAG_W-1:0]  tag_q  [NUM_ENT],
    input  logic [TAG_W-1:0]  mask_q [NUM_ENT],
    input  logic [ASID_W-1:0] asid_q [NUM_ENT],
    input  logic              glob_q [NUM_ENT],
    output logic              hit    [NUM_ENT],
    output logic              odd    [NUM_ENT]
);
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        logic [ADDR_W-1:0] emask;
        logic              tag_eq;
        logic              asid_ok;
        // Compare tag outside the mask, qualify by address space, pick half.
        always_comb begin
            emask   = {mask_q[g], {OFF_W{1'b1}}};
            tag_eq  = (((va[ADDR_W-1:OFF_W] ^ tag_q[g]) & ~mask_q[g]) == '0);
            asid_ok = glob_q[g] || (asid_q[g] == cur_asid);
            hit[g]  = tag_eq && asid_ok;
            odd[g]  = |(va & emask & ~(emask >> 1));
        end
    end
endmodule

// File: rtl/ptlb_select.sv
// Priority pick of the lowest found entry and outcome formation.
// Assumes: frame numbers of large pages carry zeros below the page size.
module ptlb_select #(
    parameter int NUM_ENT = 16,
    parameter int ADDR_W  = 32,
    parameter int MIN_PG  = 12,
    localparam int OFF_W  = MIN_PG + 1,
    localparam int TAG_W  = ADDR_W - OFF_W,
    localparam int PFN_W  = ADDR_W - MIN_PG,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic [ADDR_W-1:0] va,
    input  logic              is_write,
    input  logic              hit    [NUM_ENT],
    input  logic              odd    [NUM_ENT],
    input  logic [TAG_W-1:0]  mask_q [NUM_ENT],
    input  logic [PFN_W-1:0]  pfn0_q [NUM_ENT],
    input  logic              v0_q   [NUM_ENT],
    input  logic              d0_q   [NUM_ENT],
    input  logic [PFN_W-1:0]  pfn1_q [NUM_ENT],
    input  logic              v1_q   [NUM_ENT],
    input  logic              d1_q   [NUM_ENT],
    output logic [ADDR_W-1:0] pa,
    output logic              rd_ok,
    output logic              wr_ok,
    output ptlb_pkg::ptlb_res_e result
);
    import ptlb_pkg::*;

    logic             found;
    logic [IDX_W-1:0] win;
    logic             h_odd, h_v, h_d;
    logic [PFN_W-1:0] h_pfn;
    logic [ADDR_W-1:0] off_mask;

    // Lowest index wins: scan downward so the last assignment is the lowest.
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (hit[i]) begin
                found = 1'b1;
                win   = IDX_W'(i);
            end
        end
    end

    // Fetch the chosen half and build the outcome.
    always_comb begin
        h_odd    = odd[win];
        h_v      = h_odd ? v1_q[win]   : v0_q[win];
        h_d      = h_odd ? d1_q[win]   : d0_q[win];
        h_pfn    = h_odd ? pfn1_q[win] : pfn0_q[win];
        off_mask = {1'b0, mask_q[win], {MIN_PG{1'b1}}};
        pa       = '0;
        rd_ok    = 1'b0;
        wr_ok    = 1'b0;
        if (!found) begin
            result = RES_MISS;
        end else if (!h_v) begin
            result = RES_INVALID;
        end else if (is_write && !h_d) begin
            result = RES_MODIFIED;
        end else begin
            result = RES_HIT;
            pa     = {h_pfn, {MIN_PG{1'b0}}} | (va & off_mask);
            rd_ok  = 1'b1;
            wr_ok  = h_d;
        end
    end
endmodule

// File: rtl/ptlb_lookup.sv
// Top: paired-page translation lookup with an entry write port.
// Assumes: lookup inputs are stable for the cycle; results are combinational.
module ptlb_lookup #(
    parameter int NUM_ENT = 16,
    parameter int ADDR_W  = 32,
    parameter int MIN_PG  = 12,
    parameter int ASID_W  = 8,
    localparam int TAG_W  = ADDR_W - MIN_PG - 1,
    localparam int PFN_W  = ADDR_W - MIN_PG,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_va,
    input  logic              lk_write,
    input  logic [ASID_W-1:0] lk_asid,
    output logic [ADDR_W-1:0] lk_pa,
    output logic              lk_rd_ok,
    output logic              lk_wr_ok,
    output logic [2:0]        lk_result,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [TAG_W-1:0]  wr_mask,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic [PFN_W-1:0]  wr_pfn_even,
    input  logic              wr_v_even,
    input  logic              wr_d_even,
    input  logic [PFN_W-1:0]  wr_pfn_odd,
    input  logic              wr_v_odd,
    input  logic              wr_d_odd
);
    logic [TAG_W-1:0]  tag_q  [NUM_ENT];
    logic [TAG_W-1:0]  mask_q [NUM_ENT];
    logic [ASID_W-1:0] asid_q [NUM_ENT];
    logic              glob_q [NUM_ENT];
    logic [PFN_W-1:0]  pfn0_q [NUM_ENT];
    logic              v0_q   [NUM_ENT];
    logic              d0_q   [NUM_ENT];
    logic [PFN_W-1:0]  pfn1_q [NUM_ENT];
    logic              v1_q   [NUM_ENT];
    logic              d1_q   [NUM_ENT];
    logic              hit    [NUM_ENT];
    logic              odd    [NUM_ENT];
    ptlb_pkg::ptlb_res_e res;

    ptlb_store #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_tag(wr_tag), .wr_mask(wr_mask), .wr_asid(wr_asid), .wr_global(wr_global),
        .wr_pfn_even(wr_pfn_even), .wr_v_even(wr_v_even), .wr_d_even(wr_d_even),
        .wr_pfn_odd(wr_pfn_odd), .wr_v_odd(wr_v_odd), .wr_d_odd(wr_d_odd),
        .tag_q(tag_q), .mask_q(mask_q), .asid_q(asid_q), .glob_q(glob_q),
        .pfn0_q(pfn0_q), .v0_q(v0_q), .d0_q(d0_q),
        .pfn1_q(pfn1_q), .v1_q(v1_q), .d1_q(d1_q)
    );

    ptlb_match #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W), .MIN_PG(MIN_PG), .ASID_W(ASID_W)) u_match (
        .va(lk_va), .cur_asid(lk_asid),
        .tag_q(tag_q), .mask_q(mask_q), .asid_q(asid_q), .glob_q(glob_q),
        .hit(hit), .odd(odd)
    );

    ptlb_select #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W), .MIN_PG(MIN_PG)) u_select (
        .va(lk_va), .is_write(lk_write), .hit(hit), .odd(odd), .mask_q(mask_q),
        .pfn0_q(pfn0_q), .v0_q(v0_q), .d0_q(d0_q),
        .pfn1_q(pfn1_q), .v1_q(v1_q), .d1_q(d1_q),
        .pa(lk_pa), .rd_ok(lk_rd_ok), .wr_ok(lk_wr_ok), .result(res)
    );

    // Present the outcome code as a plain field.
    always_comb lk_result = res;
endmodule

// Output-relation checker, sampled at every clock edge out of reset.
module ptlb_chk #(
    parameter int ADDR_W = 32,
    parameter int MIN_PG = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] lk_va,
    input logic              lk_write,
    input logic [ADDR_W-1:0] lk_pa,
    input logic              lk_rd_ok,
    input logic              lk_wr_ok,
    input logic [2:0]        lk_result
);
    // R8
    nohit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_result != 3'd0) |-> (!lk_rd_ok && !lk_wr_ok && lk_pa == '0));
    // R7
    hit_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_result == 3'd0) |-> (lk_rd_ok && lk_pa[MIN_PG-1:0] == lk_va[MIN_PG-1:0]));
    // R6
    store_hit_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_result == 3'd0 && lk_write) |-> lk_wr_ok);
    // R6
    modified_on_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_result == 3'd3) |-> lk_write);
    // R5
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_result <= 3'd3);
endmodule

bind ptlb_lookup ptlb_chk #(.ADDR_W(ADDR_W), .MIN_PG(MIN_PG)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_write(lk_write), .lk_pa(lk_pa),
    .lk_rd_ok(lk_rd_ok), .lk_wr_ok(lk_wr_ok), .lk_result(lk_result)
);

// File: tb/sim_ptlb_lookup.sv
module sim_ptlb_lookup;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_write = 1'b0;
    logic [7:0]  lk_asid = '0;
    logic [31:0] lk_pa;
    logic        lk_rd_ok, lk_wr_ok;
    logic [2:0]  lk_result;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [18:0] wr_tag = '0, wr_mask = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0;
    logic [19:0] wr_pfn_even = '0, wr_pfn_odd = '0;
    logic        wr_v_even = 1'b0, wr_d_even = 1'b0, wr_v_odd = 1'b0, wr_d_odd = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ptlb_lookup u0 (.*);

    task automatic expect_out(input string req, input logic [2:0] e_res,
                              input logic [31:0] e_pa, input logic e_rd, input logic e_wr);
        n_chk++;
        if (lk_result !== e_res || lk_pa !== e_pa || lk_rd_ok !== e_rd || lk_wr_ok !== e_wr) begin
            n_bad++;
            $display("FAIL %s: got res=%0d pa=%h rd=%b wr=%b, expected res=%0d pa=%h rd=%b wr=%b",
                     req, lk_result, lk_pa, lk_rd_ok, lk_wr_ok, e_res, e_pa, e_rd, e_wr);
        end
    endtask

    task automatic probe(input logic [31:0] va, input logic wr, input logic [7:0] asid);
        @(negedge clk);
        lk_va = va; lk_write = wr; lk_asid = asid;
        #2;
    endtask

    task automatic load(input int idx, input logic [18:0] tag, input logic [18:0] mask,
                        input logic [7:0] asid, input logic g,
                        input logic [19:0] p0, input logic v0, input logic d0,
                        input logic [19:0] p1, input logic v1, input logic d1);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_tag = tag; wr_mask = mask; wr_asid = asid;
        wr_global = g; wr_pfn_even = p0; wr_v_even = v0; wr_d_even = d0;
        wr_pfn_odd = p1; wr_v_odd = v1; wr_d_odd = d1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        probe(32'h0040_0123, 1'b0, 8'h05); expect_out("R1", 3'd1, 32'h0, 1'b0, 1'b0);
        probe(32'h0000_0000, 1'b1, 8'h01); expect_out("R1", 3'd1, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_small_page();
        load(0, 19'h00200, 19'h0, 8'h05, 1'b0, 20'h12345, 1'b1, 1'b1, 20'h0ABCD, 1'b1, 1'b0);
        probe(32'h0040_0123, 1'b0, 8'h05); expect_out("R7 even read", 3'd0, 32'h1234_5123, 1'b1, 1'b1);
        probe(32'h0040_0123, 1'b1, 8'h05); expect_out("R7 even write", 3'd0, 32'h1234_5123, 1'b1, 1'b1);
        probe(32'h0040_1456, 1'b0, 8'h05); expect_out("R4 odd read", 3'd0, 32'h0ABC_D456, 1'b1, 1'b0);
        probe(32'h0040_1456, 1'b1, 8'h05); expect_out("R6 modified", 3'd3, 32'h0, 1'b0, 1'b0);
        probe(32'h0040_2000, 1'b0, 8'h05); expect_out("R2 tag miss", 3'd1, 32'h0, 1'b0, 1'b0);
        probe(32'h0040_0123, 1'b0, 8'h06); expect_out("R3 asid miss", 3'd1, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_large_page();
        load(1, 19'h08000, 19'h0000F, 8'h77, 1'b1, 20'h20000, 1'b1, 1'b1, 20'h30000, 1'b1, 1'b1);
        probe(32'h1000_ABCD, 1'b0, 8'h03); expect_out("R3 global", 3'd0, 32'h2000_ABCD, 1'b1, 1'b1);
        probe(32'h1001_2345, 1'b1, 8'h03); expect_out("R4 bit16 odd", 3'd0, 32'h3000_2345, 1'b1, 1'b1);
        probe(32'h1000_F000, 1'b0, 8'h03); expect_out("R2 masked bits", 3'd0, 32'h2000_F000, 1'b1, 1'b1);
        probe(32'h1002_0000, 1'b0, 8'h03); expect_out("R2 above mask", 3'd1, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_invalid();
        load(2, 19'h00400, 19'h0, 8'h05, 1'b0, 20'h00011, 1'b0, 1'b1, 20'h00055, 1'b1, 1'b1);
        probe(32'h0080_0010, 1'b0, 8'h05); expect_out("R5 read", 3'd2, 32'h0, 1'b0, 1'b0);
        probe(32'h0080_0010, 1'b1, 8'h05); expect_out("R5 write", 3'd2, 32'h0, 1'b0, 1'b0);
        probe(32'h0080_1010, 1'b0, 8'h05); expect_out("R7 odd valid", 3'd0, 32'h0005_5010, 1'b1, 1'b1);
    endtask

    task automatic t_priority();
        load(4, 19'h00600, 19'h0, 8'h05, 1'b0, 20'h00444, 1'b1, 1'b1, 20'h0, 1'b0, 1'b0);
        load(3, 19'h00600, 19'h0, 8'h05, 1'b0, 20'h00333, 1'b1, 1'b1, 20'h0, 1'b0, 1'b0);
        probe(32'h00C0_0abc, 1'b0, 8'h05); expect_out("R9 lowest", 3'd0, 32'h0033_3abc, 1'b1, 1'b1);
        load(3, 19'h00600, 19'h0, 8'h05, 1'b0, 20'h00333, 1'b0, 1'b1, 20'h0, 1'b0, 1'b0);
        probe(32'h00C0_0abc, 1'b0, 8'h05); expect_out("R9 lowest invalid", 3'd2, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_write_timing();
        @(negedge clk);
        lk_va = 32'h00E0_0321; lk_write = 1'b0; lk_asid = 8'h05;
        wr_en = 1'b1; wr_idx = 4'd7; wr_tag = 19'h00700; wr_mask = '0; wr_asid = 8'h05;
        wr_global = 1'b0; wr_pfn_even = 20'h00777; wr_v_even = 1'b1; wr_d_even = 1'b0;
        wr_pfn_odd = '0; wr_v_odd = 1'b0; wr_d_odd = 1'b0;
        #2;
        expect_out("R10 same cycle old", 3'd1, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
        #2;
        expect_out("R10 next cycle new", 3'd0, 32'h0077_7321, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_small_page();
        t_large_page();
        t_invalid();
        t_priority();
        t_write_timing();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got hung run, expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule